// File: doc/BRIEF.md
# Half-Duplex Line Direction Arbiter

This block joins two open-drain data lines, one on the host side and one on the card side, for half-duplex smart-card traffic. Neither side has a fixed role. While a card session is open and reception is enabled, the first line seen falling becomes the input. The block then copies that line's level onto the other line through an open-drain drive-low output. When the input line rises again, both lines are released and the block waits for the next falling edge.

Both line inputs pass through a synchroniser of `SYNC_STAGES` flops. Each line then has an edge detector. A three-state machine holds the direction. Its states are NEUTRAL (both lines released), HOST_IN (host line is the input, card line is the copy) and CARD_IN (card line is the input, host line is the copy).

The transitions are:
- NEUTRAL to HOST_IN on a host fall. A host fall wins a tie.
- NEUTRAL to CARD_IN on a card fall when the host line does not fall in the same cycle.
- HOST_IN to NEUTRAL on a host rise.
- CARD_IN to NEUTRAL on a card rise.
- Any state to NEUTRAL whenever the block is disabled.

Outside an enabled session, the card-side line is held low and the host-side line is left high.

Top module: `io_dir_arbiter`

## Requirements
- R1: With both enables low after reset, `card_drive_low_o` is 1 and `host_drive_low_o` is 0.
- R2: While `session_en` or `rx_en` is 0, the card line is held low, the host line is released, and a host line falling in that time starts no transfer once the block is enabled.
- R3: When the host line falls first in NEUTRAL, `card_drive_low_o` goes to 1 three clock edges after the change, and it then follows the inverted host level.
- R4: When the card line falls first in NEUTRAL, `host_drive_low_o` goes to 1 three clock edges after the change, and it then follows the inverted card level.
- R5: When both lines fall in the same cycle, the host side becomes the input: the card line is driven and the host line is not.
- R6: A rise on the input line releases the output drive within two clock edges and returns the machine to NEUTRAL.
- R7: In HOST_IN or CARD_IN, edges on the output line cause no change of direction.
- R8: Dropping either enable forces NEUTRAL. After re-enabling, with a line already low, neither side is driven.
- R9: While the block is enabled, `host_drive_low_o` and `card_drive_low_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| session_en | input | 1 | Card session open |
| rx_en | input | 1 | Reception state enabled |
| host_line_i | input | 1 | Sensed level of the host-side line |
| card_line_i | input | 1 | Sensed level of the card-side line |
| host_drive_low_o | output | 1 | Pull the host-side line low |
| card_drive_low_o | output | 1 | Pull the card-side line low |

## Verification
A line change is seen as a synchronised level after `SYNC_STAGES` (2) clock edges. One more edge is needed to register the direction, so a drive-low output turns on three edges after a falling stimulus. Releasing the input line clears the copy after two edges, because the copy follows the synchronised level directly. The effect of an enable is combinational, and it is checked one edge after the enable changes. The bench changes its stimulus on falling clock edges and waits exactly these edge counts before it samples. It also checks the cycle just before the due cycle, so that early responses are caught as well as late ones.

// File: rtl/io_arb_pkg.sv
package io_arb_pkg;
    typedef enum logic [1:0] {
        ST_NEUTRAL = 2'd0,
        ST_HOST_IN = 2'd1,
        ST_CARD_IN = 2'd2
    } arb_state_t;

    localparam int SIDE_HOST = 0;
    localparam int SIDE_CARD = 1;
    localparam int NUM_SIDES = 2;
endpackage

// File: rtl/io_line_sampler.sv
module io_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic fall_o,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level_d;

    // Idle-high reset value, so no edge is reported out of reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '1;
            level_d <= 1'b1;
        end else begin
            sync_q  <= {sync_q[SYNC_STAGES-2:0], line_i};
            level_d <= sync_q[SYNC_STAGES-1];
        end
    end

    assign level_o = sync_q[SYNC_STAGES-1];
    assign fall_o  = level_d & ~level_o;
    assign rise_o  = ~level_d & level_o;
endmodule

// File: rtl/io_arb_fsm.sv
module io_arb_fsm
    import io_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enabled_i,
    input  logic       host_fall_i,
    input  logic       host_rise_i,
    input  logic       card_fall_i,
    input  logic       card_rise_i,
    output arb_state_t state_o
);
    arb_state_t state_q, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NEUTRAL;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        if (!enabled_i) begin
            state_n = ST_NEUTRAL;
        end else begin
            unique case (state_q)
                ST_NEUTRAL: begin
                    // Host side wins a same-cycle tie
                    if (host_fall_i)      state_n = ST_HOST_IN;
                    else if (card_fall_i) state_n = ST_CARD_IN;
                end
                ST_HOST_IN: if (host_rise_i) state_n = ST_NEUTRAL;
                ST_CARD_IN: if (card_rise_i) state_n = ST_NEUTRAL;
                default:    state_n = ST_NEUTRAL;
            endcase
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/io_arb_drive.sv
module io_arb_drive
    import io_arb_pkg::*;
(
    input  arb_state_t state_i,
    input  logic       enabled_i,
    input  logic       host_level_i,
    input  logic       card_level_i,
    output logic       host_drive_low_o,
    output logic       card_drive_low_o
);
    always_comb begin
        host_drive_low_o = 1'b0;
        card_drive_low_o = 1'b0;
        if (!enabled_i) begin
            card_drive_low_o = 1'b1;
        end else begin
            unique case (state_i)
                ST_NEUTRAL: ;
                ST_HOST_IN: card_drive_low_o = ~host_level_i;
                ST_CARD_IN: host_drive_low_o = ~card_level_i;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/io_dir_arbiter.sv
module io_dir_arbiter
    import io_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic session_en,
    input  logic rx_en,
    input  logic host_line_i,
    input  logic card_line_i,
    output logic host_drive_low_o,
    output logic card_drive_low_o
);
    logic [NUM_SIDES-1:0] line_in, level, fall, rise;
    logic                 enabled;
    arb_state_t           state;

    assign enabled            = session_en & rx_en;
    assign line_in[SIDE_HOST] = host_line_i;
    assign line_in[SIDE_CARD] = card_line_i;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        io_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (line_in[s]),
            .level_o (level[s]),
            .fall_o  (fall[s]),
            .rise_o  (rise[s])
        );
    end

    io_arb_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enabled_i   (enabled),
        .host_fall_i (fall[SIDE_HOST]),
        .host_rise_i (rise[SIDE_HOST]),
        .card_fall_i (fall[SIDE_CARD]),
        .card_rise_i (rise[SIDE_CARD]),
        .state_o     (state)
    );

    io_arb_drive u_drive (
        .state_i          (state),
        .enabled_i        (enabled),
        .host_level_i     (level[SIDE_HOST]),
        .card_level_i     (level[SIDE_CARD]),
        .host_drive_low_o (host_drive_low_o),
        .card_drive_low_o (card_drive_low_o)
    );
endmodule

// File: rtl/io_dir_arbiter_chk.sv
module io_dir_arbiter_chk
    import io_arb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       session_en,
    input logic       rx_en,
    input logic       host_drive_low_o,
    input logic       card_drive_low_o,
    input arb_state_t state,
    input logic [1:0] fall,
    input logic [1:0] rise
);
    logic en;
    assign en = session_en & rx_en;

    assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (card_drive_low_o && !host_drive_low_o));

    assert_tie_host_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == ST_NEUTRAL && fall[SIDE_HOST] && fall[SIDE_CARD])
        |=> state == ST_HOST_IN);

    assert_input_rise_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == ST_HOST_IN && rise[SIDE_HOST]) |=> state == ST_NEUTRAL);

    assert_output_edge_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && state == ST_HOST_IN && !rise[SIDE_HOST]
         && (fall[SIDE_CARD] || rise[SIDE_CARD])) |=> state == ST_HOST_IN);

    assert_disable_neutral_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == ST_NEUTRAL);

    assert_one_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> !(host_drive_low_o && card_drive_low_o));
endmodule

bind io_dir_arbiter io_dir_arbiter_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .session_en       (session_en),
    .rx_en            (rx_en),
    .host_drive_low_o (host_drive_low_o),
    .card_drive_low_o (card_drive_low_o),
    .state            (state),
    .fall             (fall),
    .rise             (rise)
);

// File: tb/tb_io_dir_arbiter.sv
module tb_io_dir_arbiter;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic session_en = 1'b0, rx_en = 1'b0;
    logic host_ext_low = 1'b0, card_ext_low = 1'b0;
    logic host_drive_low_o, card_drive_low_o;
    logic host_line, card_line;
    int   n_checks = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Open-drain wired lines: low if either party pulls
    assign host_line = ~(host_drive_low_o | host_ext_low);
    assign card_line = ~(card_drive_low_o | card_ext_low);

    io_dir_arbiter dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .session_en       (session_en),
        .rx_en            (rx_en),
        .host_line_i      (host_line),
        .card_line_i      (card_line),
        .host_drive_low_o (host_drive_low_o),
        .card_drive_low_o (card_drive_low_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {host_drv,card_drv} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic enable_idle();
        session_en = 1'b1; rx_en = 1'b1;
        step(4);
        check("R8 idle", {host_drive_low_o, card_drive_low_o}, 2'b00);
    endtask

    task automatic t_reset_R1();
        step(1);
        check("R1", {host_drive_low_o, card_drive_low_o}, 2'b01);
        rst_n = 1'b1;
        step(2);
        check("R1", {host_drive_low_o, card_drive_low_o}, 2'b01);
    endtask

    task automatic t_disabled_R2();
        host_ext_low = 1'b1;
        step(4);
        check("R2 held", {host_drive_low_o, card_drive_low_o}, 2'b01);
        session_en = 1'b1; rx_en = 1'b1;
        step(4);
        check("R2 no start", {host_drive_low_o, card_drive_low_o}, 2'b00);
        host_ext_low = 1'b0;
        step(4);
        check("R2 idle", {host_drive_low_o, card_drive_low_o}, 2'b00);
    endtask

    task automatic t_host_in_R3_R6_R7();
        host_ext_low = 1'b1;
        step(2);
        check("R3 early", {host_drive_low_o, card_drive_low_o}, 2'b00);
        step(1);
        check("R3", {host_drive_low_o, card_drive_low_o}, 2'b01);
        card_ext_low = 1'b1;   // output line edges must be ignored
        step(3);
        card_ext_low = 1'b0;
        step(3);
        check("R7", {host_drive_low_o, card_drive_low_o}, 2'b01);
        host_ext_low = 1'b0;
        step(1);
        check("R6 early", {host_drive_low_o, card_drive_low_o}, 2'b01);
        step(1);
        check("R6", {host_drive_low_o, card_drive_low_o}, 2'b00);
        step(4);
        check("R6 neutral", {host_drive_low_o, card_drive_low_o}, 2'b00);
    endtask

    task automatic t_card_in_R4_R6();
        card_ext_low = 1'b1;
        step(2);
        check("R4 early", {host_drive_low_o, card_drive_low_o}, 2'b00);
        step(1);
        check("R4", {host_drive_low_o, card_drive_low_o}, 2'b10);
        card_ext_low = 1'b0;
        step(2);
        check("R6 card", {host_drive_low_o, card_drive_low_o}, 2'b00);
        card_ext_low = 1'b1;   // a fresh fall starts a new transfer
        step(3);
        check("R4 again", {host_drive_low_o, card_drive_low_o}, 2'b10);
        card_ext_low = 1'b0;
        step(4);
        check("R6 card idle", {host_drive_low_o, card_drive_low_o}, 2'b00);
    endtask

    task automatic t_tie_R5();
        host_ext_low = 1'b1; card_ext_low = 1'b1;
        step(3);
        check("R5", {host_drive_low_o, card_drive_low_o}, 2'b01);
        host_ext_low = 1'b0;
        step(4);
        check("R5 release", {host_drive_low_o, card_drive_low_o}, 2'b00);
        card_ext_low = 1'b0;
        step(4);
        check("R5 idle", {host_drive_low_o, card_drive_low_o}, 2'b00);
    endtask

    task automatic t_disable_R8();
        host_ext_low = 1'b1;
        step(3);
        check("R8 pre", {host_drive_low_o, card_drive_low_o}, 2'b01);
        rx_en = 1'b0;
        step(1);
        check("R8 forced", {host_drive_low_o, card_drive_low_o}, 2'b01);
        rx_en = 1'b1;
        step(1);
        check("R8 neutral", {host_drive_low_o, card_drive_low_o}, 2'b00);
        host_ext_low = 1'b0;
        step(4);
        card_ext_low = 1'b1;
        step(3);
        check("R8 card pre", {host_drive_low_o, card_drive_low_o}, 2'b10);
        session_en = 1'b0;
        step(1);
        check("R8 session drop", {host_drive_low_o, card_drive_low_o}, 2'b01);
        card_ext_low = 1'b0;
        session_en = 1'b1;
        step(4);
        check("R8 after", {host_drive_low_o, card_drive_low_o}, 2'b00);
    endtask

    initial begin
        fork
            begin
                t_reset_R1();
                t_disabled_R2();
                enable_idle();
                t_host_in_R3_R6_R7();
                t_card_in_R4_R6();
                t_tie_R5();
                t_disable_R8();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // R9 sampled every cycle while enabled
    always @(negedge clk) begin
        if (rst_n && session_en && rx_en && host_drive_low_o && card_drive_low_o) begin
            n_checks++; n_fail++;
            $display("FAIL R9: actual=11 expected=not both");
        end
    end
endmodule